// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a logical address, given as a segment selector plus an offset, into a linear address. It works in one of two modes, chosen by a live mode input. In real mode the visible segment register is shifted left by four bit positions and the low 16 bits of the offset are added, giving a 20-bit address that wraps and is zero-extended. In protected mode, writing the segment register starts a fetch of one descriptor. The fetch goes through a simple request/response memory port, from the local or the global table. The decoded descriptor is held in a hidden cache, and every later translation uses it. Each translation is checked against the presence bit, against the limit scaled by granularity and, for stack accesses through a small-stack segment, against a 64 KB bound.

Translation has one cycle of latency: a request accepted at a clock edge returns its linear address and fault flags on the registered outputs right after that edge. While a descriptor fetch is in progress in protected mode, requests are held off with a stall signal. The cached attribute fields that this block does not use are passed on to the protection logic next to it.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, out_valid, dreq_valid and xl_stall are low, and the hidden descriptor is marked not present: a protected-mode translation before any load reports a not-present fault.
- R2: In real mode, a request accepted at a clock edge yields, right after that edge, out_valid=1, out_linear = zero-extended ((selector << 4) + offset[15:0]) modulo 2^20, and both fault flags low.
- R3: In real mode, a selector write takes effect for requests in later cycles. A request in the same cycle as the write translates with the previous selector value.
- R4: A protected-mode selector write, accepted while no load is in progress, raises dreq_valid for exactly one cycle after the write edge. The request address is (selector bit 2 ? gdt_base : ldt_base) + selector[15:3]*8.
- R5: The response word received with drsp_valid while the unit waits is decoded as base = [31:0], limit = [51:32], granularity = [52], present = [53], privilege = [55:54], application = [56], big = [57], type = [61:58] and spare = [63:62]. seg_attr shows {spare, type, application, privilege, selector[1:0]}.
- R6: In protected mode, xl_stall is high in the cycle of a selector write and for the whole load, until the response cycle. A stalled request produces no out_valid.
- R7: The effective limit is {limit, 12'hFFF} when granularity is 1 and the zero-extended limit when it is 0. An offset above it raises out_flt_limit.
- R8: A stack request (xl_stack=1) through a descriptor whose big bit is 0 raises out_flt_limit when the offset exceeds 32'h0000FFFF, even if the offset is within the limit.
- R9: A protected translation through a descriptor with present=0 raises out_flt_np, keeps out_flt_limit low and gives out_linear=0.
- R10: A protected translation without a fault gives out_linear = base + offset modulo 2^32. With any fault, out_linear is 0.
- R11: Selector writes made while a load is in progress are ignored. They start no new request and change neither the visible selector nor the cached descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_prot | input | 1 | 1 = protected mode, 0 = real mode |
| sel_wr_en | input | 1 | Write the visible selector |
| sel_wr_val | input | 16 | Selector value to write |
| ldt_base | input | 32 | Base address of the local table |
| gdt_base | input | 32 | Base address of the global table |
| dreq_valid | output | 1 | Descriptor read request, one cycle |
| dreq_addr | output | 32 | Descriptor address |
| drsp_valid | input | 1 | Descriptor read response valid |
| drsp_data | input | 64 | Descriptor word |
| xl_valid | input | 1 | Translation request |
| xl_offset | input | 32 | Offset within the segment |
| xl_stack | input | 1 | Request is a stack access |
| xl_stall | output | 1 | Request not accepted this cycle |
| out_valid | output | 1 | Translation result valid |
| out_linear | output | 32 | Linear address (0 on fault) |
| out_flt_limit | output | 1 | Limit or stack-bound fault |
| out_flt_np | output | 1 | Segment-not-present fault |
| seg_attr | output | 11 | Cached attribute fields and requestor privilege |

## Verification
A selector write and a translation request can land in the same cycle. In real mode the request must then use the old segment value. In protected mode the request must be stalled and the descriptor fetch must start. The bench drives both inputs on one falling edge. It checks xl_stall before the next rising edge, then checks whether out_valid appears, the translated address, and whether dreq_valid appears after that edge. It also writes a second selector during an open fetch and checks that no second request appears and that the visible selector keeps its value.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int unsigned SEG_BASE_W = 32;
   localparam int unsigned SEG_LIM_W  = 20;
   localparam int unsigned SEG_WORD_W = 64;

   typedef struct packed {
      logic [1:0]            spare;
      logic [3:0]            kind;
      logic                  big;
      logic                  app;
      logic [1:0]            dpl;
      logic                  present;
      logic                  gran;
      logic [SEG_LIM_W-1:0]  limit;
      logic [SEG_BASE_W-1:0] base;
   } seg_desc_t;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_ISSUE = 2'd1,
      LD_WAIT  = 2'd2
   } ld_state_t;

   function automatic seg_desc_t seg_unpack(input logic [SEG_WORD_W-1:0] w);
      seg_desc_t d;
      d = seg_desc_t'(w);
      return d;
   endfunction
endpackage

// File: rtl/seg_desc_loader.sv
module seg_desc_loader #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 13,
   parameter int unsigned WORD_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [IDX_W:0]      sel_hi,
   input  logic [ADDR_W-1:0]   ldt_base,
   input  logic [ADDR_W-1:0]   gdt_base,
   input  logic                rsp_valid,
   input  logic [WORD_W-1:0]   rsp_word,
   output logic                busy,
   output logic                req_valid,
   output logic [ADDR_W-1:0]   req_addr,
   output seg_pkg::seg_desc_t  desc
);
   import seg_pkg::*;

   localparam int unsigned ENTRY_SH = 3;

   ld_state_t            st_q;
   logic [ADDR_W-1:0]    addr_q;
   seg_desc_t            desc_q;
   logic [ADDR_W-1:0]    tbl_base;
   logic [ADDR_W-1:0]    idx_off;
   logic                 go;

   assign go       = start && (st_q == LD_IDLE);
   assign tbl_base = sel_hi[0] ? gdt_base : ldt_base;
   assign idx_off  = ADDR_W'({sel_hi[IDX_W:1], {ENTRY_SH{1'b0}}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= LD_IDLE;
         addr_q <= '0;
         desc_q <= '0;
      end else begin
         unique case (st_q)
            LD_IDLE: begin
               if (go) begin
                  st_q   <= LD_ISSUE;
                  addr_q <= tbl_base + idx_off;
               end
            end
            LD_ISSUE: st_q <= LD_WAIT;
            LD_WAIT: begin
               if (rsp_valid) begin
                  desc_q <= seg_unpack(rsp_word);
                  st_q   <= LD_IDLE;
               end
            end
            default: st_q <= LD_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != LD_IDLE);
   assign req_valid = (st_q == LD_ISSUE);
   assign req_addr  = addr_q;
   assign desc      = desc_q;
endmodule

// File: rtl/seg_real_xlat.sv
module seg_real_xlat #(
   parameter int unsigned SEG_W  = 16,
   parameter int unsigned SHIFT  = 4,
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned OUT_W  = 32
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [OUT_W-1:0] lin
);
   localparam int unsigned RM_W = SEG_W + SHIFT;

   logic [RM_W-1:0] sum;

   assign sum = {seg, {SHIFT{1'b0}}} + RM_W'(off);
   assign lin = OUT_W'(sum);
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check #(
   parameter int unsigned LIN_W     = 32,
   parameter int unsigned GRAN_SH   = 12,
   parameter int unsigned STACK_CHK = 1
) (
   input  seg_pkg::seg_desc_t desc,
   input  logic [LIN_W-1:0]   off,
   input  logic               stack,
   output logic               flt_np,
   output logic               flt_lim,
   output logic [LIN_W-1:0]   lin
);
   localparam logic [LIN_W-1:0] SMALL_STACK_TOP = LIN_W'(32'h0000_FFFF);

   logic [LIN_W-1:0] eff_lim;
   logic             over_lim;
   logic             over_stk;

   assign eff_lim  = desc.gran ? {desc.limit, {GRAN_SH{1'b1}}} : LIN_W'(desc.limit);
   assign over_lim = (off > eff_lim);

   generate
      if (STACK_CHK != 0) begin : g_stk
         assign over_stk = stack && !desc.big && (off > SMALL_STACK_TOP);
      end else begin : g_nostk
         logic unused_stk;
         assign unused_stk = stack;
         assign over_stk   = 1'b0;
      end
   endgenerate

   assign flt_np  = !desc.present;
   assign flt_lim = desc.present && (over_lim || over_stk);
   assign lin     = (flt_np || flt_lim) ? '0 : desc.base + off;
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit #(
   parameter int unsigned LIN_W     = 32,
   parameter int unsigned SEL_W     = 16,
   parameter int unsigned RM_SHIFT  = 4,
   parameter int unsigned RM_OFF_W  = 16,
   parameter int unsigned WORD_W    = 64,
   parameter int unsigned STACK_CHK = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_prot,
   input  logic               sel_wr_en,
   input  logic [SEL_W-1:0]   sel_wr_val,
   input  logic [LIN_W-1:0]   ldt_base,
   input  logic [LIN_W-1:0]   gdt_base,
   output logic               dreq_valid,
   output logic [LIN_W-1:0]   dreq_addr,
   input  logic               drsp_valid,
   input  logic [WORD_W-1:0]  drsp_data,
   input  logic               xl_valid,
   input  logic [LIN_W-1:0]   xl_offset,
   input  logic               xl_stack,
   output logic               xl_stall,
   output logic               out_valid,
   output logic [LIN_W-1:0]   out_linear,
   output logic               out_flt_limit,
   output logic               out_flt_np,
   output logic [10:0]        seg_attr
);
   import seg_pkg::*;

   localparam int unsigned RM_W    = SEL_W + RM_SHIFT;
   localparam int unsigned IDX_W   = SEL_W - 3;
   localparam int unsigned GRAN_SH = LIN_W - SEG_LIM_W;

   generate
      if (RM_W > LIN_W) begin : g_bad_rm
         $error("real-mode address wider than linear address");
      end
      if (RM_OFF_W > RM_W) begin : g_bad_off
         $error("real-mode offset wider than real-mode address");
      end
      if (LIN_W != SEG_BASE_W) begin : g_bad_lin
         $error("linear width must match descriptor base width");
      end
      if (WORD_W != SEG_WORD_W) begin : g_bad_word
         $error("descriptor word width mismatch");
      end
      if (SEL_W < 4) begin : g_bad_sel
         $error("selector too narrow");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   logic             ld_busy;
   logic             ld_start;
   seg_desc_t        desc;
   logic             accept;
   logic             wr_ok;

   logic [LIN_W-1:0] rm_lin;
   logic [LIN_W-1:0] pm_lin;
   logic             pm_np;
   logic             pm_lim;

   assign wr_ok    = sel_wr_en && !ld_busy;
   assign ld_start = wr_ok && mode_prot;
   assign xl_stall = mode_prot && (ld_busy || sel_wr_en);
   assign accept   = xl_valid && !xl_stall;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else if (wr_ok) sel_q <= sel_wr_val;
   end

   seg_desc_loader #(
      .ADDR_W (LIN_W),
      .IDX_W  (IDX_W),
      .WORD_W (WORD_W)
   ) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ld_start),
      .sel_hi    (sel_wr_val[SEL_W-1:2]),
      .ldt_base  (ldt_base),
      .gdt_base  (gdt_base),
      .rsp_valid (drsp_valid),
      .rsp_word  (drsp_data),
      .busy      (ld_busy),
      .req_valid (dreq_valid),
      .req_addr  (dreq_addr),
      .desc      (desc)
   );

   seg_real_xlat #(
      .SEG_W (SEL_W),
      .SHIFT (RM_SHIFT),
      .OFF_W (RM_OFF_W),
      .OUT_W (LIN_W)
   ) u_real (
      .seg (sel_q),
      .off (xl_offset[RM_OFF_W-1:0]),
      .lin (rm_lin)
   );

   seg_prot_check #(
      .LIN_W     (LIN_W),
      .GRAN_SH   (GRAN_SH),
      .STACK_CHK (STACK_CHK)
   ) u_check (
      .desc    (desc),
      .off     (xl_offset),
      .stack   (xl_stack),
      .flt_np  (pm_np),
      .flt_lim (pm_lim),
      .lin     (pm_lin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_linear    <= '0;
         out_flt_limit <= 1'b0;
         out_flt_np    <= 1'b0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_linear    <= mode_prot ? pm_lin : rm_lin;
            out_flt_limit <= mode_prot && pm_lim;
            out_flt_np    <= mode_prot && pm_np;
         end
      end
   end

   assign seg_attr = {desc.spare, desc.kind, desc.app, desc.dpl, sel_q[1:0]};
endmodule

// File: rtl/seg_xlat_unit_chk.sv
module seg_xlat_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mode_prot,
   input logic        dreq_valid,
   input logic        xl_valid,
   input logic        xl_stall,
   input logic        out_valid,
   input logic [31:0] out_linear,
   input logic        out_flt_limit,
   input logic        out_flt_np
);
   a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      dreq_valid |=> !dreq_valid);

   a_r6_stall_during_req: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_valid && mode_prot) |-> xl_stall);

   a_r6_result_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(xl_valid && !xl_stall));

   a_r9_np_excludes_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flt_np) |-> !out_flt_limit);

   a_r10_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_flt_np || out_flt_limit)) |-> (out_linear == 32'h0));

   a_r2_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!mode_prot)) |-> (!out_flt_np && !out_flt_limit && out_linear[31:20] == 12'h0));
endmodule

bind seg_xlat_unit seg_xlat_unit_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_prot     (mode_prot),
   .dreq_valid    (dreq_valid),
   .xl_valid      (xl_valid),
   .xl_stall      (xl_stall),
   .out_valid     (out_valid),
   .out_linear    (out_linear),
   .out_flt_limit (out_flt_limit),
   .out_flt_np    (out_flt_np)
);

// File: tb/seg_xlat_unit_bench.sv
module seg_xlat_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_prot = 1'b0;
   logic        sel_wr_en = 1'b0;
   logic [15:0] sel_wr_val = '0;
   logic [31:0] ldt_base = 32'h0010_0000;
   logic [31:0] gdt_base = 32'h0800_0000;
   logic        dreq_valid;
   logic [31:0] dreq_addr;
   logic        drsp_valid = 1'b0;
   logic [63:0] drsp_data = '0;
   logic        xl_valid = 1'b0;
   logic [31:0] xl_offset = '0;
   logic        xl_stack = 1'b0;
   logic        xl_stall;
   logic        out_valid;
   logic [31:0] out_linear;
   logic        out_flt_limit;
   logic        out_flt_np;
   logic [10:0] seg_attr;

   int n_chk = 0;
   int n_fail = 0;

   logic [15:0] m_sel = '0;
   logic [31:0] m_base = '0;
   logic [19:0] m_lim = '0;
   logic        m_gran = 1'b0;
   logic        m_pres = 1'b0;
   logic        m_big = 1'b0;

   always #10 clk = ~clk;

   seg_xlat_unit u_seg_xlat_unit (
      .clk(clk), .rst_n(rst_n), .mode_prot(mode_prot),
      .sel_wr_en(sel_wr_en), .sel_wr_val(sel_wr_val),
      .ldt_base(ldt_base), .gdt_base(gdt_base),
      .dreq_valid(dreq_valid), .dreq_addr(dreq_addr),
      .drsp_valid(drsp_valid), .drsp_data(drsp_data),
      .xl_valid(xl_valid), .xl_offset(xl_offset), .xl_stack(xl_stack),
      .xl_stall(xl_stall), .out_valid(out_valid), .out_linear(out_linear),
      .out_flt_limit(out_flt_limit), .out_flt_np(out_flt_np), .seg_attr(seg_attr)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_word(input logic [31:0] b, input logic [19:0] l,
                                          input bit g, input bit p, input bit bg, input logic [8:0] extra);
      return {extra[8:7], extra[6:3], bg, extra[2], extra[1:0], p, g, l, b};
   endfunction

   function automatic void expect_x(input bit prot, input logic [31:0] off, input bit stk,
                                    output logic [31:0] lin, output bit fl, output bit fn);
      logic [19:0] s;
      logic [31:0] eff;
      if (!prot) begin
         s = {m_sel, 4'h0} + {4'h0, off[15:0]};
         lin = {12'h0, s}; fl = 0; fn = 0;
      end else if (!m_pres) begin
         lin = 0; fl = 0; fn = 1;
      end else begin
         eff = m_gran ? {m_lim, 12'hFFF} : {12'h0, m_lim};
         fn = 0;
         fl = (off > eff) || (stk && !m_big && off > 32'hFFFF);
         lin = fl ? 32'h0 : m_base + off;
      end
   endfunction

   task automatic xlat(input logic [31:0] off, input bit stk, input string req);
      logic [31:0] el; bit efl, efn;
      @(negedge clk);
      xl_valid = 1; xl_offset = off; xl_stack = stk;
      expect_x(mode_prot, off, stk, el, efl, efn);
      @(negedge clk);
      xl_valid = 0;
      chk(out_valid === 1'b1, req, 64'(out_valid), 64'd1);
      chk(out_linear === el, req, 64'(out_linear), 64'(el));
      chk(out_flt_limit === efl, req, 64'(out_flt_limit), 64'(efl));
      chk(out_flt_np === efn, req, 64'(out_flt_np), 64'(efn));
   endtask

   task automatic real_sel(input logic [15:0] s);
      @(negedge clk); sel_wr_en = 1; sel_wr_val = s;
      @(negedge clk); sel_wr_en = 0;
      m_sel = s;
   endtask

   // protected load; assumes mode_prot=1 and selector already driven for one cycle by caller when pre=1
   task automatic finish_load(input logic [15:0] s, input logic [63:0] w, input int lat, input bit ign);
      logic [31:0] ea;
      ea = (s[2] ? gdt_base : ldt_base) + {16'h0, s[15:3], 3'b000};
      chk(dreq_valid === 1'b1, "R4 request raised", 64'(dreq_valid), 64'd1);
      chk(dreq_addr === ea, "R4 request address", 64'(dreq_addr), 64'(ea));
      @(negedge clk);
      chk(dreq_valid === 1'b0, "R4 request one cycle", 64'(dreq_valid), 64'd0);
      if (ign) begin
         sel_wr_en = 1; sel_wr_val = ~s;
         @(negedge clk);
         sel_wr_en = 0;
      end
      for (int i = 0; i < lat; i++) begin
         chk(xl_stall === 1'b1, "R6 stall while loading", 64'(xl_stall), 64'd1);
         @(negedge clk);
      end
      drsp_valid = 1; drsp_data = w;
      @(negedge clk);
      drsp_valid = 0;
      m_sel = s; m_base = w[31:0]; m_lim = w[51:32]; m_gran = w[52]; m_pres = w[53]; m_big = w[57];
      chk(xl_stall === 1'b0, "R6 stall released", 64'(xl_stall), 64'd0);
   endtask

   task automatic prot_load(input logic [15:0] s, input logic [63:0] w, input int lat);
      @(negedge clk); sel_wr_en = 1; sel_wr_val = s;
      #1 chk(xl_stall === 1'b1, "R6 stall on write cycle", 64'(xl_stall), 64'd1);
      @(negedge clk); sel_wr_en = 0;
      finish_load(s, w, lat, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] el; bit efl, efn;
      logic [63:0] w;
      logic [15:0] s;
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 0);
      chk(dreq_valid === 1'b0, "R1 dreq_valid", 64'(dreq_valid), 0);
      chk(xl_stall === 1'b0, "R1 xl_stall", 64'(xl_stall), 0);
      mode_prot = 1;
      xlat(32'h10, 0, "R1 not present after reset");
      mode_prot = 0;

      // R2 real mode, including wrap
      real_sel(16'h1100); xlat(32'hABCD_0450, 0, "R2 real basic");
      real_sel(16'hFFFF); xlat(32'h0000_FFFF, 0, "R2 real wrap");

      // R3 same-cycle write in real mode uses old value
      @(negedge clk); sel_wr_en = 1; sel_wr_val = 16'h2222; xl_valid = 1; xl_offset = 32'h33;
      expect_x(0, 32'h33, 0, el, efl, efn);
      @(negedge clk); sel_wr_en = 0; xl_valid = 0;
      chk(out_linear === el, "R3 same-cycle old selector", 64'(out_linear), 64'(el));
      m_sel = 16'h2222;
      xlat(32'h33, 0, "R3 new selector later");

      // R4/R5/R7/R10 byte granularity, local table
      mode_prot = 1;
      w = mk_word(32'h4000_0000, 20'h00FFF, 0, 1, 1, 9'h1A5);
      prot_load(16'h0013, w, 2);
      chk(seg_attr === {2'b11, 4'h4, 1'b1, 2'b01, 2'b11}, "R5 attributes", 64'(seg_attr),
          64'({2'b11, 4'h4, 1'b1, 2'b01, 2'b11}));
      xlat(32'h0000_0FFF, 0, "R7 offset at limit");
      xlat(32'h0000_1000, 0, "R7 offset above limit");
      xlat(32'h0000_0123, 0, "R10 base plus offset");

      // R7 4 KB granularity, global table
      w = mk_word(32'hF000_1000, 20'h00002, 1, 1, 1, 9'h0);
      prot_load(16'h0FFC, w, 0);
      xlat(32'h0000_2FFF, 0, "R7 scaled limit top");
      xlat(32'h0000_3000, 0, "R7 scaled limit over");

      // R8 small stack bound
      w = mk_word(32'h0000_0000, 20'hFFFFF, 1, 1, 0, 9'h0);
      prot_load(16'h0020, w, 1);
      xlat(32'h0001_0000, 1, "R8 stack over 64K");
      xlat(32'h0001_0000, 0, "R8 non-stack unaffected");
      xlat(32'h0000_FFFF, 1, "R8 stack at 64K top");

      // R9 not present
      w = mk_word(32'h1234_0000, 20'hFFFFF, 1, 0, 1, 9'h0);
      prot_load(16'h0008, w, 0);
      xlat(32'h5, 0, "R9 not present");

      // R6 same-cycle write and request in protected mode
      @(negedge clk); sel_wr_en = 1; sel_wr_val = 16'h0030; xl_valid = 1; xl_offset = 32'h4;
      #1 chk(xl_stall === 1'b1, "R6 stall on collision", 64'(xl_stall), 1);
      @(negedge clk); sel_wr_en = 0; xl_valid = 0;
      chk(out_valid === 1'b0, "R6 stalled request dropped", 64'(out_valid), 0);
      w = mk_word(32'h0000_8000, 20'h000FF, 0, 1, 1, 9'h0);
      finish_load(16'h0030, w, 1, 0);
      xlat(32'h4, 0, "R6 request after load");

      // R11 write during load ignored
      @(negedge clk); sel_wr_en = 1; sel_wr_val = 16'h0045;
      @(negedge clk); sel_wr_en = 0;
      w = mk_word(32'h0200_0000, 20'h0FFFF, 0, 1, 1, 9'h0);
      finish_load(16'h0045, w, 1, 1);
      for (int i = 0; i < 3; i++) begin
         chk(dreq_valid === 1'b0, "R11 no second request", 64'(dreq_valid), 0);
         @(negedge clk);
      end
      xlat(32'h100, 0, "R11 cached descriptor kept");
      mode_prot = 0;
      xlat(32'h100, 0, "R11 visible selector kept");

      // random mix
      for (int it = 0; it < 300; it++) begin
         int unsigned r;
         logic [31:0] off, eff;
         r = $urandom_range(0, 9);
         if (r < 3) begin
            mode_prot = 0;
            if (r == 0) real_sel(16'($urandom));
            xlat($urandom, 0, "R2 random real");
         end else begin
            mode_prot = 1;
            if (r == 3) begin
               s = 16'($urandom);
               w = mk_word($urandom, 20'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0),
                           1'($urandom), 9'($urandom));
               prot_load(s, w, $urandom_range(0, 3));
            end
            eff = m_gran ? {m_lim, 12'hFFF} : {12'h0, m_lim};
            case ($urandom_range(0, 3))
               0: off = eff;
               1: off = eff + 1;
               2: off = 32'h0000_FFFF + 32'($urandom_range(0, 1));
               default: off = $urandom;
            endcase
            xlat(off, 1'($urandom), "R10 random protected");
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule